// File: doc/BRIEF.md
# Delayed Lockstep Output Comparator

This block watches a functional processing unit and a redundant checker unit that receives the same inputs but runs a fixed number of cycles behind. It delays the functional output bus by that lag and compares the delayed copy with the checker output on every clock cycle. Any difference is reported as a one-cycle compare-error to the system error aggregator, and it also sets a sticky status bit.

A key-protected mode write lets software prove the error path. Writing the self-test key arms an error-forcing mode. For exactly one cycle the delayed functional word is inverted before the compare, so a compare error must follow. The mode then falls back to normal compare by itself. A debug-halt input masks error reporting while a debugger holds the cores.

Top module: `lockstep_cmp`

## Requirements
- R1: After reset `cmpErr`, `errStatus` and `forceActive` are all 0.
- R2: The functional bus is delayed by LAG cycles (default 2). `cmpErr` after clock edge n is 1 exactly when `chkOut` sampled at edge n differs from `funcOut` sampled at edge n-LAG, given no forcing and no halt. When the checker follows exactly LAG cycles behind, no error is raised.
- R3: A difference in any single bit of the compared words raises `cmpErr` for one cycle only. A checker that is not lagging, so that it matches the current functional word rather than the delayed one, is reported as a mismatch.
- R4: A mode write (`keyWrEn`=1) with `keyWrData`=4'h9 sets `forceActive` after that edge. In the following cycle the delayed functional word is inverted before the compare, so `cmpErr` is 1 after the next edge. `forceActive` then returns to 0 without any further write.
- R5: A mode write with key 4'h0 selects normal compare. A mode write with any key other than 4'h9 or 4'h0 leaves the mode unchanged. Neither one forces an error.
- R6: While `dbgHalt` is 1 at an edge, `cmpErr` stays 0 after that edge and `errStatus` is not set, both for real mismatches and for forced ones. A forced injection that falls during a halt is consumed and is not replayed later.
- R7: `errStatus` is set whenever `cmpErr` is raised and stays set until a status write (`statWrEn`=1) with `statWrBit`=1. A status write with `statWrBit`=0 has no effect. A new error in the same cycle as a clear wins, and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| funcOut | input | DATA_W | Output bus of the functional unit |
| chkOut | input | DATA_W | Output bus of the lagging checker unit |
| keyWrEn | input | 1 | Mode key write strobe |
| keyWrData | input | KEY_W | Mode key value |
| statWrEn | input | 1 | Status write strobe |
| statWrBit | input | 1 | Write-1-to-clear data for the sticky status |
| dbgHalt | input | 1 | Debug halt, masks error reporting |
| cmpErr | output | 1 | One-cycle compare-error to the error aggregator and pin |
| errStatus | output | 1 | Sticky compare-error status |
| forceActive | output | 1 | Error-forcing injection armed for the current cycle |

## Verification
The hardest case to reach is a forced injection that lands in a cycle where `dbgHalt` is high, while the checker stream is otherwise perfectly matched. The stimulus arms the key and raises halt on the very next edge. It then shows that no error appears, that the sticky bit stays clear, and that the mode has returned to normal so no late error leaks out once halt drops. The bench keeps its own two-deep history of the functional words, so every checker value it drives is matched or corrupted relative to the correctly skewed word.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_FORCE  = 1'b1
  } cmpMode_e;

  typedef struct packed {
    logic injectNow;
    logic reportEn;
  } cmpStrobe_t;

endpackage

// File: rtl/lockstep_delay_dp.sv
module lockstep_delay_dp
  import lockstep_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAG    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] funcOut,
  input  logic [DATA_W-1:0] chkOut,
  input  cmpStrobe_t        strobe,
  output logic              diffNow,
  output logic              cmpErr
);

  logic [DATA_W-1:0] stageQ [LAG];
  logic [DATA_W-1:0] skewed;

  // delay line: stage 0 takes the live bus, each later stage the one before
  for (genvar s = 0; s < LAG; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageQ[s] <= '0;
      end else if (s == 0) begin
        stageQ[s] <= funcOut;
      end else begin
        stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign skewed  = stageQ[LAG-1] ^ {DATA_W{strobe.injectNow}};
  assign diffNow = (skewed != chkOut);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpErr <= 1'b0;
    end else begin
      cmpErr <= diffNow && strobe.reportEn;
    end
  end

endmodule

// File: rtl/lockstep_mode_ctrl.sv
module lockstep_mode_ctrl
  import lockstep_pkg::*;
#(
  parameter int          KEY_W     = 4,
  parameter logic [KEY_W-1:0] KEY_FORCE = 4'h9,
  parameter logic [KEY_W-1:0] KEY_NORM  = 4'h0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             keyWrEn,
  input  logic [KEY_W-1:0] keyWrData,
  input  logic             statWrEn,
  input  logic             statWrBit,
  input  logic             dbgHalt,
  input  logic             diffNow,
  output cmpStrobe_t       strobe,
  output logic             errStatus,
  output logic             forceActive
);

  cmpMode_e modeQ, modeD;
  logic     setNow;
  logic     clrNow;

  always_comb begin
    modeD = MODE_NORMAL;  // forcing lasts one cycle, then falls back
    if (keyWrEn && (keyWrData == KEY_FORCE)) begin
      modeD = MODE_FORCE;
    end else if (keyWrEn && (keyWrData == KEY_NORM)) begin
      modeD = MODE_NORMAL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_NORMAL;
    end else begin
      modeQ <= modeD;
    end
  end

  assign strobe.injectNow = (modeQ == MODE_FORCE);
  assign strobe.reportEn  = !dbgHalt;
  assign forceActive      = (modeQ == MODE_FORCE);

  assign setNow = diffNow && strobe.reportEn;
  assign clrNow = statWrEn && statWrBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errStatus <= 1'b0;
    end else if (setNow) begin
      errStatus <= 1'b1;
    end else if (clrNow) begin
      errStatus <= 1'b0;
    end
  end

endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lockstep_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAG    = 2,
  parameter int KEY_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] funcOut,
  input  logic [DATA_W-1:0] chkOut,
  input  logic              keyWrEn,
  input  logic [KEY_W-1:0]  keyWrData,
  input  logic              statWrEn,
  input  logic              statWrBit,
  input  logic              dbgHalt,
  output logic              cmpErr,
  output logic              errStatus,
  output logic              forceActive
);

  cmpStrobe_t strobe;
  logic       diffNow;

  lockstep_mode_ctrl #(
    .KEY_W     (KEY_W),
    .KEY_FORCE (KEY_W'(9)),
    .KEY_NORM  (KEY_W'(0))
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .keyWrEn     (keyWrEn),
    .keyWrData   (keyWrData),
    .statWrEn    (statWrEn),
    .statWrBit   (statWrBit),
    .dbgHalt     (dbgHalt),
    .diffNow     (diffNow),
    .strobe      (strobe),
    .errStatus   (errStatus),
    .forceActive (forceActive)
  );

  lockstep_delay_dp #(
    .DATA_W (DATA_W),
    .LAG    (LAG)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .funcOut (funcOut),
    .chkOut  (chkOut),
    .strobe  (strobe),
    .diffNow (diffNow),
    .cmpErr  (cmpErr)
  );

endmodule

// File: rtl/lockstep_cmp_sva.sv
module lockstep_cmp_sva #(
  parameter int KEY_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             keyWrEn,
  input logic [KEY_W-1:0] keyWrData,
  input logic             statWrEn,
  input logic             statWrBit,
  input logic             dbgHalt,
  input logic             cmpErr,
  input logic             errStatus,
  input logic             forceActive
);

  assert_force_ends_R4: assert property (@(posedge clk) disable iff (!rstN)
    (forceActive && !(keyWrEn && keyWrData == KEY_W'(9))) |=> !forceActive);

  assert_force_hits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (forceActive && !dbgHalt) |=> cmpErr);

  assert_other_key_R5: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrEn && keyWrData != KEY_W'(9)) |=> !forceActive);

  assert_halt_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    dbgHalt |=> !cmpErr);

  assert_err_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmpErr |-> errStatus);

  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errStatus && !(statWrEn && statWrBit)) |=> errStatus);

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!errStatus && !cmpErr) |=> (cmpErr == errStatus));

endmodule

bind lockstep_cmp lockstep_cmp_sva #(.KEY_W(KEY_W)) u_sva (
  .clk         (clk),
  .rstN        (rstN),
  .keyWrEn     (keyWrEn),
  .keyWrData   (keyWrData),
  .statWrEn    (statWrEn),
  .statWrBit   (statWrBit),
  .dbgHalt     (dbgHalt),
  .cmpErr      (cmpErr),
  .errStatus   (errStatus),
  .forceActive (forceActive)
);

// File: tb/lockstep_cmp_tb.sv
module lockstep_cmp_tb;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN;
  logic [W-1:0] funcOut, chkOut;
  logic         keyWrEn;
  logic [3:0]   keyWrData;
  logic         statWrEn, statWrBit, dbgHalt;
  logic         cmpErr, errStatus, forceActive;

  int nChecks = 0;
  int nFails  = 0;
  logic [W-1:0] fh1 = '0, fh2 = '0;  // functional words one and two edges back

  always #2 clk = ~clk;

  lockstep_cmp #(.DATA_W(W), .LAG(2), .KEY_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .funcOut(funcOut), .chkOut(chkOut),
    .keyWrEn(keyWrEn), .keyWrData(keyWrData), .statWrEn(statWrEn),
    .statWrBit(statWrBit), .dbgHalt(dbgHalt), .cmpErr(cmpErr),
    .errStatus(errStatus), .forceActive(forceActive)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive on negedge, checker = functional two back xor flip
  task automatic step(input logic [W-1:0] f, input logic [W-1:0] flip,
                      input logic kEn, input logic [3:0] k,
                      input logic cEn, input logic cBit, input logic halt);
    @(negedge clk);
    funcOut = f; chkOut = fh2 ^ flip;
    keyWrEn = kEn; keyWrData = k;
    statWrEn = cEn; statWrBit = cBit; dbgHalt = halt;
    @(posedge clk);
    fh2 = fh1; fh1 = f;
    #1;
  endtask

  task automatic idle(input logic [W-1:0] f);
    step(f, '0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic clear_status();
    step(32'h1111_0000, '0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0);
    check("R7 clear", errStatus, 1'b0);
  endtask

  task automatic t_reset();
    rstN = 1'b0; funcOut = '0; chkOut = '0; keyWrEn = 0; keyWrData = '0;
    statWrEn = 0; statWrBit = 0; dbgHalt = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 cmpErr", cmpErr, 1'b0);
    check("R1 errStatus", errStatus, 1'b0);
    check("R1 forceActive", forceActive, 1'b0);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic t_match();
    for (int i = 0; i < 12; i++) begin
      idle(32'hA5A5_0000 ^ (32'h1 << i) ^ (i * 32'h0101_0101));
      check("R2 skewed match", cmpErr, 1'b0);
    end
    check("R2 no status", errStatus, 1'b0);
  endtask

  task automatic t_mismatch();
    idle(32'h0000_0001);
    step(32'h0000_0002, 32'h8000_0000, 0, 4'h0, 0, 0, 0);
    check("R3 msb flip", cmpErr, 1'b1);
    check("R7 set", errStatus, 1'b1);
    idle(32'h0000_0003);
    check("R3 one cycle", cmpErr, 1'b0);
    step(32'h0000_0004, 32'h0000_0001, 0, 4'h0, 0, 0, 0);
    check("R3 lsb flip", cmpErr, 1'b1);
    idle(32'h0000_0005);
    // checker not lagging: equals current functional word
    @(negedge clk);
    funcOut = 32'hDEAD_BEEF; chkOut = 32'hDEAD_BEEF;
    @(posedge clk); fh2 = fh1; fh1 = 32'hDEAD_BEEF; #1;
    check("R2 unskewed caught", cmpErr, 1'b1);
    idle(32'h0);
    idle(32'h0);
    check("R2 back in step", cmpErr, 1'b0);
  endtask

  task automatic t_sticky();
    check("R7 held", errStatus, 1'b1);
    step(32'h7, '0, 0, 4'h0, 1'b1, 1'b0, 0);
    check("R7 write 0 ignored", errStatus, 1'b1);
    clear_status();
    // set wins over clear in the same cycle
    step(32'h8, 32'h10, 0, 4'h0, 1'b1, 1'b1, 0);
    check("R7 set beats clear", errStatus, 1'b1);
    clear_status();
  endtask

  task automatic t_force();
    step(32'h9, '0, 1'b1, 4'h9, 0, 0, 0);
    check("R4 armed", forceActive, 1'b1);
    check("R4 no early err", cmpErr, 1'b0);
    idle(32'hA);
    check("R4 forced err", cmpErr, 1'b1);
    check("R4 auto return", forceActive, 1'b0);
    check("R4 status", errStatus, 1'b1);
    idle(32'hB);
    check("R4 single inject", cmpErr, 1'b0);
    clear_status();
  endtask

  task automatic t_keys();
    step(32'hC, '0, 1'b1, 4'h5, 0, 0, 0);
    check("R5 other key", forceActive, 1'b0);
    step(32'hD, '0, 1'b1, 4'h0, 0, 0, 0);
    check("R5 normal key", forceActive, 1'b0);
    check("R5 no err", cmpErr, 1'b0);
    idle(32'hE);
    check("R5 still no err", cmpErr, 1'b0);
    check("R5 status clear", errStatus, 1'b0);
  endtask

  task automatic t_halt();
    step(32'h10, '0, 1'b1, 4'h9, 0, 0, 0);
    step(32'h11, '0, 0, 4'h0, 0, 0, 1'b1);
    check("R6 forced masked", cmpErr, 1'b0);
    check("R6 status masked", errStatus, 1'b0);
    check("R6 inject consumed", forceActive, 1'b0);
    idle(32'h12);
    check("R6 no replay", cmpErr, 1'b0);
    step(32'h13, 32'hFF, 0, 4'h0, 0, 0, 1'b1);
    check("R6 mismatch masked", cmpErr, 1'b0);
    check("R6 mismatch status", errStatus, 1'b0);
    step(32'h14, 32'hFF, 0, 4'h0, 0, 0, 1'b0);
    check("R6 halt released", cmpErr, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        idle(32'h0);
        idle(32'h0);
        t_match();
        t_mismatch();
        t_sticky();
        t_force();
        t_keys();
        t_halt();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule